// File: doc/BRIEF.md
# Smart card supply sequencing controller

This block powers one smart card slot up and down under control of a single 8-bit control/status register. The host writes a non-zero supply code into the voltage field. The block then switches the slot supply on at that level and waits for the supply-good indication. After that it enables the card I/O line, starts the card clock, and releases card reset once a set number of card clock ticks has passed. A card clock tick is a one-cycle pulse made by a divider outside the block.

Power-down always runs in a fixed order: reset is asserted, then the clock stops, then I/O is disabled, and only then is the supply removed. Each step is held for a fixed number of system clocks. Power-down starts when the host writes a zero supply code, or when the block sees a card-presence event, a loss of supply-good, a supply-ready timeout or a VDD fault. When the cause is not the host, a lockout is set. While it is set, the supply code left in the register does not start the slot again. The host clears the lockout by writing a zero supply code.

Two active-low companion command outputs tell an external supply circuit which rail to drive. A mode bit decides whether a VDD fault forces both of them high at once or leaves the whole response to the host.

Top module: `card_supply_seq`

## Requirements
- R1: The supply code in register bits 7:6 selects the level: 00 = off, 01 = 1.8 V, 10 = 3.0 V, 11 = 5 V. While the supply is on, `supplyLevel` carries the code latched when activation started. `highRailCmdN` is low for code 11 and `lowRailCmdN` is low for codes 01 and 10. Both are high while the supply is off.
- R2: A register write that leaves a non-zero supply code, with no lockout set, turns `supplyEn` on at the second clock edge after the write edge.
- R3: Activation order is: supply on, then wait for `supplyGood`. After `supplyGood`, `cardIoEn` rises. `cardClkEn` rises STEP_DLY cycles after `cardIoEn`. `cardRstN` rises on the edge that consumes the RST_DELAY-th card clock tick counted while the clock is enabled (RST_DELAY defaults to 400).
- R4: Writing supply code 00 while powered runs power-down: `cardRstN` falls first, then `cardClkEn`, then `cardIoEn`, then `supplyEn`, with STEP_DLY cycles (default 4) between each pair of steps.
- R5: A `cardEvent` pulse, or `supplyGood` falling after it has been seen, starts power-down and sets the lockout (register bit 2).
- R6: While the lockout is set, the supply stays off even with a non-zero supply code in the register. Writing code 00 clears the lockout, and a later non-zero write starts activation again.
- R7: With fault mode (bit 5) = 0, a `vddFault` drives both companion outputs high in the same cycle, starts power-down and sets the lockout.
- R8: With fault mode = 1, `vddFault` does not affect the sequence or the companion outputs. The host powers down by writing code 00, and the companion outputs go high when the supply turns off.
- R9: With ready mode (bit 4) = 0, if `supplyGood` has not arrived READY_TIMEOUT cycles (default 1024) after the supply turned on, power-down starts and the lockout is set. With ready mode = 1, the block waits for `supplyGood` without a limit.
- R10: A power-down cause that arrives during activation cuts it short and enters the reset step first, with clock and I/O still on for STEP_DLY cycles.
- R11: The register resets to 0x00. Bits 7:4 and 0 are writable. Reading returns bit 3 = busy, bit 2 = lockout and bit 1 = live `supplyGood`. Bit 0 is the power-down bit and drives `lowPower` (1 = low-power mode).
- R12: The busy bit is set from the start of any activation or power-down until it finishes, and is clear while the slot is idle off or fully active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data |
| supplyGood | input | 1 | Slot supply is stable |
| cardEvent | input | 1 | Card insertion/removal pulse |
| vddFault | input | 1 | Chip supply fault indication |
| cardClkTick | input | 1 | One pulse per card clock cycle |
| supplyEn | output | 1 | Slot supply enable |
| supplyLevel | output | 2 | Active supply code, 00 when off |
| cardRstN | output | 1 | Card reset line, low = reset |
| cardClkEn | output | 1 | Card clock enable |
| cardIoEn | output | 1 | Card I/O enable |
| lowRailCmdN | output | 1 | Active-low command for 1.8 V / 3.0 V rail |
| highRailCmdN | output | 1 | Active-low command for 5 V rail |
| lowPower | output | 1 | Interface low-power mode |

## Verification
The embedded assertions check, on every cycle, the nesting of the card lines: a running clock implies I/O on, released reset implies a running clock, and I/O implies supply. They also check that an immediate-mode fault forces both companion outputs high, that a locked slot stays off, that a timeout leaves the supply wait for the reset step, and that a card event drops reset. The directed scenarios are what show the exact step spacing, the number of card clock ticks before reset is released, the 1036-cycle lifetime of a supply that never becomes good, and the recovery path out of lockout. They also show that a fault is ignored in host-handled mode and that a preempted activation starts its power-down at the reset step.

// File: rtl/card_supply_pkg.sv
package card_supply_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_PWR_WAIT,
    ST_IO_ON,
    ST_CLK_RUN,
    ST_ACTIVE,
    ST_DN_RST,
    ST_DN_CLK,
    ST_DN_IO
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic latchTarget;
    logic setLock;
    logic setForce;
    logic clrForce;
  } seqStrobe_t;

  // datapath -> control counter flags
  typedef struct packed {
    logic stepDone;
    logic rstDelayDone;
    logic readyExpired;
  } cntFlags_t;

  localparam int SEL_HI_BIT    = 7;
  localparam int SEL_LO_BIT    = 6;
  localparam int FAULTMODE_BIT = 5;
  localparam int READYMODE_BIT = 4;
  localparam int PDN_BIT       = 0;

endpackage

// File: rtl/card_supply_dp.sv
module card_supply_dp
  import card_supply_pkg::*;
#(
  parameter int STEP_DLY      = 4,
  parameter int RST_DELAY     = 400,
  parameter int READY_TIMEOUT = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       supplyGood,
  input  logic       busy,
  input  seqStrobe_t strobe,
  output logic [1:0] selCfg,
  output logic       faultMode,
  output logic       readyMode,
  output logic       powerDown,
  output logic [1:0] target,
  output logic       lockOut,
  output logic       forceOff,
  output cntFlags_t  flags,
  output logic [7:0] rdData
);

  localparam int CNT_MAX_A = (STEP_DLY > RST_DELAY) ? STEP_DLY : RST_DELAY;
  localparam int CNT_MAX   = (CNT_MAX_A > READY_TIMEOUT) ? CNT_MAX_A : READY_TIMEOUT;
  localparam int CW        = $clog2(CNT_MAX + 1);

  logic [CW-1:0] cnt;
  logic          unusedWr;

  assign unusedWr = ^wrData[3:1];

  // host-visible configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selCfg    <= 2'b00;
      faultMode <= 1'b0;
      readyMode <= 1'b0;
      powerDown <= 1'b0;
    end else if (wrEn) begin
      selCfg    <= wrData[SEL_HI_BIT:SEL_LO_BIT];
      faultMode <= wrData[FAULTMODE_BIT];
      readyMode <= wrData[READYMODE_BIT];
      powerDown <= wrData[PDN_BIT];
    end
  end

  // target latched at activation start, lockout and forced-off state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      target   <= 2'b00;
      lockOut  <= 1'b0;
      forceOff <= 1'b0;
    end else begin
      if (strobe.latchTarget) target <= selCfg;
      if (strobe.setLock)          lockOut <= 1'b1;
      else if (selCfg == 2'b00)    lockOut <= 1'b0;
      if (strobe.setForce)         forceOff <= 1'b1;
      else if (strobe.clrForce)    forceOff <= 1'b0;
    end
  end

  // shared step / tick / timeout counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntInc) cnt <= cnt + 1'b1;
  end

  assign flags.stepDone     = (cnt == CW'(STEP_DLY - 1));
  assign flags.rstDelayDone = (cnt == CW'(RST_DELAY - 1));
  assign flags.readyExpired = (cnt == CW'(READY_TIMEOUT - 1));

  assign rdData = {selCfg, faultMode, readyMode, busy, lockOut, supplyGood, powerDown};

  // a lockout is only dropped after the host has cleared the supply code
  assert_lock_needs_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockOut) |-> $past(selCfg) == 2'b00);

endmodule

// File: rtl/card_supply_ctrl.sv
module card_supply_ctrl
  import card_supply_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] selCfg,
  input  logic       faultMode,
  input  logic       readyMode,
  input  logic       lockOut,
  input  logic       forceOff,
  input  logic [1:0] target,
  input  cntFlags_t  flags,
  input  logic       supplyGood,
  input  logic       cardEvent,
  input  logic       vddFault,
  input  logic       cardClkTick,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       supplyEn,
  output logic [1:0] supplyLevel,
  output logic       cardRstN,
  output logic       cardClkEn,
  output logic       cardIoEn,
  output logic       lowRailCmdN,
  output logic       highRailCmdN
);

  seqState_e state, nextState;
  logic faultHit, hostOff, upPhase, railLost, readyTimeout, lockCause, cmdOff;

  assign faultHit     = vddFault && !faultMode;
  assign hostOff      = (selCfg == 2'b00);
  assign upPhase      = state inside {ST_PWR_WAIT, ST_IO_ON, ST_CLK_RUN, ST_ACTIVE};
  assign railLost     = (state inside {ST_IO_ON, ST_CLK_RUN, ST_ACTIVE}) && !supplyGood;
  assign readyTimeout = (state == ST_PWR_WAIT) && !readyMode && !supplyGood && flags.readyExpired;
  assign lockCause    = cardEvent || faultHit || railLost || readyTimeout;

  always_comb begin
    nextState          = state;
    strobe             = '0;
    strobe.setForce    = faultHit && (state != ST_OFF);
    strobe.clrForce    = (state == ST_OFF);
    if (state == ST_OFF) begin
      if (!hostOff && !lockOut) begin
        nextState          = ST_PWR_WAIT;
        strobe.latchTarget = 1'b1;
      end
    end else if (upPhase && (lockCause || hostOff)) begin
      nextState      = ST_DN_RST;
      strobe.setLock = lockCause;
    end else begin
      unique case (state)
        ST_PWR_WAIT: if (supplyGood) nextState = ST_IO_ON;
        ST_IO_ON:    if (flags.stepDone) nextState = ST_CLK_RUN;
        ST_CLK_RUN:  if (cardClkTick && flags.rstDelayDone) nextState = ST_ACTIVE;
        ST_DN_RST:   if (flags.stepDone) nextState = ST_DN_CLK;
        ST_DN_CLK:   if (flags.stepDone) nextState = ST_DN_IO;
        ST_DN_IO:    if (flags.stepDone) nextState = ST_OFF;
        default:     nextState = state;
      endcase
    end
    strobe.cntClr = (nextState != state);
    strobe.cntInc = (state == ST_CLK_RUN) ? cardClkTick
                                          : !(state inside {ST_OFF, ST_ACTIVE});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  assign supplyEn     = (state != ST_OFF);
  assign cardIoEn     = state inside {ST_IO_ON, ST_CLK_RUN, ST_ACTIVE, ST_DN_RST, ST_DN_CLK};
  assign cardClkEn    = state inside {ST_CLK_RUN, ST_ACTIVE, ST_DN_RST};
  assign cardRstN     = (state == ST_ACTIVE);
  assign busy         = supplyEn && (state != ST_ACTIVE);
  assign supplyLevel  = supplyEn ? target : 2'b00;
  assign cmdOff       = forceOff || faultHit || !supplyEn;
  assign highRailCmdN = cmdOff || (target != 2'b11);
  assign lowRailCmdN  = cmdOff || !(target inside {2'b01, 2'b10});

  assert_clk_needs_io_R3: assert property (@(posedge clk) disable iff (!rstN)
    cardClkEn |-> cardIoEn);
  assert_rst_needs_clk_R3: assert property (@(posedge clk) disable iff (!rstN)
    cardRstN |-> cardClkEn);
  assert_io_needs_supply_R4: assert property (@(posedge clk) disable iff (!rstN)
    cardIoEn |-> supplyEn);
  assert_level_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    supplyEn |-> supplyLevel != 2'b00);
  assert_fault_cmd_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (vddFault && !faultMode) |-> (lowRailCmdN && highRailCmdN));
  assert_event_drops_rst_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cardRstN && cardEvent) |=> !cardRstN);
  assert_timeout_deact_R9: assert property (@(posedge clk) disable iff (!rstN)
    readyTimeout |=> (state == ST_DN_RST && lockOut));

endmodule

// File: rtl/card_supply_seq.sv
module card_supply_seq
  import card_supply_pkg::*;
#(
  parameter int STEP_DLY      = 4,
  parameter int RST_DELAY     = 400,
  parameter int READY_TIMEOUT = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       supplyGood,
  input  logic       cardEvent,
  input  logic       vddFault,
  input  logic       cardClkTick,
  output logic       supplyEn,
  output logic [1:0] supplyLevel,
  output logic       cardRstN,
  output logic       cardClkEn,
  output logic       cardIoEn,
  output logic       lowRailCmdN,
  output logic       highRailCmdN,
  output logic       lowPower
);

  seqStrobe_t strobe;
  cntFlags_t  flags;
  logic [1:0] selCfg, target;
  logic       faultMode, readyMode, lockOut, forceOff, busy;

  card_supply_dp #(
    .STEP_DLY(STEP_DLY), .RST_DELAY(RST_DELAY), .READY_TIMEOUT(READY_TIMEOUT)
  ) dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .supplyGood(supplyGood), .busy(busy), .strobe(strobe),
    .selCfg(selCfg), .faultMode(faultMode), .readyMode(readyMode),
    .powerDown(lowPower), .target(target), .lockOut(lockOut),
    .forceOff(forceOff), .flags(flags), .rdData(rdData)
  );

  card_supply_ctrl ctrl (
    .clk(clk), .rstN(rstN), .selCfg(selCfg), .faultMode(faultMode),
    .readyMode(readyMode), .lockOut(lockOut), .forceOff(forceOff),
    .target(target), .flags(flags), .supplyGood(supplyGood),
    .cardEvent(cardEvent), .vddFault(vddFault), .cardClkTick(cardClkTick),
    .strobe(strobe), .busy(busy), .supplyEn(supplyEn),
    .supplyLevel(supplyLevel), .cardRstN(cardRstN), .cardClkEn(cardClkEn),
    .cardIoEn(cardIoEn), .lowRailCmdN(lowRailCmdN), .highRailCmdN(highRailCmdN)
  );

  assert_lock_holds_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lockOut && !supplyEn) |=> !supplyEn);

endmodule

// File: tb/card_supply_seq_test.sv
`timescale 1ns/1ps
module card_supply_seq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       railUp = 1'b0;
  logic       supplyGood;
  logic       cardEvent = 1'b0;
  logic       vddFault = 1'b0;
  logic       cardClkTick = 1'b0;
  logic       supplyEn, cardRstN, cardClkEn, cardIoEn;
  logic       lowRailCmdN, highRailCmdN, lowPower;
  logic [1:0] supplyLevel;

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  int tickCnt = 0;
  bit finished = 1'b0;

  assign supplyGood = supplyEn && railUp;

  card_supply_seq uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .supplyGood(supplyGood), .cardEvent(cardEvent), .vddFault(vddFault),
    .cardClkTick(cardClkTick), .supplyEn(supplyEn), .supplyLevel(supplyLevel),
    .cardRstN(cardRstN), .cardClkEn(cardClkEn), .cardIoEn(cardIoEn),
    .lowRailCmdN(lowRailCmdN), .highRailCmdN(highRailCmdN), .lowPower(lowPower)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cardClkTick && cardClkEn && !cardRstN) tickCnt <= tickCnt + 1;
  end

  always @(negedge clk) if (rstN) cardClkTick <= ~cardClkTick;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitActive();
    for (int i = 0; i < 3000 && !cardRstN; i++) @(negedge clk);
  endtask

  task automatic waitOff();
    for (int i = 0; i < 3000 && supplyEn; i++) @(negedge clk);
  endtask

  task automatic bringUp(input logic [7:0] v);
    railUp = 1'b1;
    writeReg(v);
    waitActive();
  endtask

  task automatic shutdown();
    writeReg(8'h00);
    waitOff();
    step(2);
  endtask

  task automatic testReset();
    check(rdData == 8'h00, "R11 reset value", rdData, 0);
    check(!supplyEn && !cardRstN && !cardClkEn && !cardIoEn, "R11 lines idle", supplyEn, 0);
    check(lowRailCmdN && highRailCmdN, "R1 cmds high at reset", {lowRailCmdN, highRailCmdN}, 3);
  endtask

  task automatic testRegs();
    writeReg(8'h31);
    check(rdData == 8'h31, "R11 readback", rdData, 8'h31);
    check(lowPower == 1'b1, "R11 power-down bit", lowPower, 1);
    step(3);
    check(!supplyEn, "R2 zero code stays off", supplyEn, 0);
    writeReg(8'h00);
    check(lowPower == 1'b0, "R11 power-down clear", lowPower, 0);
  endtask

  task automatic testActivate();
    int tIo, tClk;
    railUp = 1'b0;
    writeReg(8'hC0);
    check(!supplyEn, "R2 not before second edge", supplyEn, 0);
    step(1);
    check(supplyEn, "R2 supply on", supplyEn, 1);
    check(supplyLevel == 2'b11, "R1 level 5V", supplyLevel, 3);
    check(!highRailCmdN && lowRailCmdN, "R1 5V rail cmd", {lowRailCmdN, highRailCmdN}, 2);
    check(rdData[3], "R12 busy while waiting", rdData[3], 1);
    step(10);
    check(!cardIoEn, "R3 io waits for good", cardIoEn, 0);
    railUp = 1'b1;
    tickCnt = 0;
    tIo = 0; tClk = 0;
    for (int i = 0; i < 3000 && !cardRstN; i++) begin
      @(negedge clk);
      if (cardIoEn && tIo == 0) tIo = cyc;
      if (cardClkEn && tClk == 0) tClk = cyc;
    end
    check(tClk - tIo == 4, "R3 clock after io", tClk - tIo, 4);
    check(tickCnt == 400, "R3 reset release ticks", tickCnt, 400);
    check(cardRstN && rdData[1] && !rdData[3], "R12 active idle bits", rdData, 8'hC2);
  endtask

  task automatic testDeact();
    int tR, tC, tI, tS;
    bit orderOk;
    writeReg(8'h00);
    tR = 0; tC = 0; tI = 0; tS = 0; orderOk = 1'b0;
    for (int i = 0; i < 200 && tS == 0; i++) begin
      @(negedge clk);
      if (!cardRstN && tR == 0) begin tR = cyc; orderOk = cardClkEn && cardIoEn; end
      if (!cardClkEn && tC == 0) tC = cyc;
      if (!cardIoEn && tI == 0) tI = cyc;
      if (!supplyEn && tS == 0) tS = cyc;
    end
    check(orderOk, "R4 reset first", orderOk, 1);
    check(tC - tR == 4, "R4 clock step", tC - tR, 4);
    check(tI - tC == 4, "R4 io step", tI - tC, 4);
    check(tS - tI == 4, "R4 supply step", tS - tI, 4);
    check(lowRailCmdN && highRailCmdN && !rdData[2], "R4 no lock on host off", rdData, 0);
  endtask

  task automatic testEventLock();
    bringUp(8'h80);
    @(negedge clk); cardEvent = 1'b1;
    @(negedge clk); cardEvent = 1'b0;
    check(!cardRstN, "R5 event drops reset", cardRstN, 0);
    waitOff();
    check(rdData[2], "R5 lockout set", rdData[2], 1);
    step(20);
    check(!supplyEn, "R6 locked stays off", supplyEn, 0);
    writeReg(8'h00);
    step(1);
    check(!rdData[2], "R6 lock cleared", rdData[2], 0);
    writeReg(8'h80);
    step(1);
    check(supplyEn, "R6 restart after clear", supplyEn, 1);
    waitActive();
    shutdown();
  endtask

  task automatic testRailLoss();
    bringUp(8'h40);
    railUp = 1'b0;
    waitOff();
    check(!supplyEn && rdData[2], "R5 good loss locks", rdData, 8'h44);
    railUp = 1'b1;
    shutdown();
  endtask

  task automatic testFaultImmediate();
    bringUp(8'hC0);
    check(!highRailCmdN, "R7 cmd low before fault", highRailCmdN, 0);
    @(negedge clk); vddFault = 1'b1;
    #1;
    check(highRailCmdN && lowRailCmdN, "R7 cmds high at once", {lowRailCmdN, highRailCmdN}, 3);
    waitOff();
    check(rdData[2], "R7 fault locks", rdData[2], 1);
    vddFault = 1'b0;
    shutdown();
  endtask

  task automatic testFaultHost();
    bringUp(8'hE0);
    @(negedge clk); vddFault = 1'b1;
    step(20);
    check(cardRstN && !highRailCmdN, "R8 fault ignored", {cardRstN, highRailCmdN}, 2);
    vddFault = 1'b0;
    writeReg(8'h20);
    waitOff();
    check(highRailCmdN && !rdData[2], "R8 host deact cmds high", highRailCmdN, 1);
    shutdown();
  endtask

  task automatic testTimeout();
    int tOn, tOff;
    railUp = 1'b0;
    writeReg(8'h80);
    tOn = 0; tOff = 0;
    for (int i = 0; i < 3000 && tOff == 0; i++) begin
      @(negedge clk);
      if (supplyEn && tOn == 0) tOn = cyc;
      if (!supplyEn && tOn != 0) tOff = cyc;
    end
    check(tOff - tOn == 1036, "R9 timeout span", tOff - tOn, 1036);
    check(rdData[2], "R9 timeout locks", rdData[2], 1);
    railUp = 1'b1;
    shutdown();
  endtask

  task automatic testReadyWait();
    railUp = 1'b0;
    writeReg(8'h90);
    step(1200);
    check(supplyEn && rdData[3], "R9 waits past timeout", {supplyEn, rdData[3]}, 3);
    railUp = 1'b1;
    waitActive();
    check(cardRstN, "R9 activates when good", cardRstN, 1);
    shutdown();
  endtask

  task automatic testPreempt();
    int tEvt, tOff;
    railUp = 1'b1;
    writeReg(8'h40);
    step(1);
    check(supplyLevel == 2'b01 && !lowRailCmdN && highRailCmdN, "R1 1.8V rail cmd",
          supplyLevel, 1);
    for (int i = 0; i < 200 && !cardClkEn; i++) @(negedge clk);
    step(3);
    @(negedge clk); cardEvent = 1'b1;
    @(negedge clk); cardEvent = 1'b0;
    tEvt = cyc;
    check(cardClkEn && cardIoEn && !cardRstN, "R10 reset step first", {cardClkEn, cardIoEn}, 3);
    tOff = 0;
    for (int i = 0; i < 50 && tOff == 0; i++) begin
      @(negedge clk);
      if (!cardClkEn) tOff = cyc;
    end
    check(tOff - tEvt == 4, "R10 clock held one step", tOff - tEvt, 4);
    waitOff();
    shutdown();
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(2);
    testReset();
    testRegs();
    testActivate();
    testDeact();
    testEventLock();
    testRailLoss();
    testFaultImmediate();
    testFaultHost();
    testTimeout();
    testReadyWait();
    testPreempt();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule